// File: doc/BRIEF.md
# Grid Dispatch Manager with Dependency Hold

This block sits between the sources of compute work and a work distributor that can run only a bounded number of grids at once. Host software feeds grids through several independent submission queues, each with its own valid/ready handshake. Running grids can feed the block in two ways through one device-side port: they can launch child grids, and a parent can suspend itself until its children finish. All pending work competes for dispatch by a 2-bit priority, with a rotating tie-break across sources. The host queues and the device side count as separate sources.

Each grid identifier has a counter of outstanding children. A child launch raises its parent's counter, and a completion report for that child lowers it. A suspended parent stays parked in the device-side pool and gives up its active slot. It becomes a dispatch candidate again only once its counter reads zero. A pause input stops new dispatch. Completion reports and suspensions are still accepted while paused, so the grids already running are not disturbed. Dispatch is reported as a single-cycle strobe, and the block counts active grids itself.

Top module: `grid_dispatch_mgr`

## Requirements
- R1: The number of active grids never exceeds MAX_ACT. When the count, after this cycle's completion and suspension, equals MAX_ACT, no grid is dispatched.
- R2: Each host queue dispatches its grids in arrival order, and only its oldest grid is a candidate. An empty queue, or a queue whose head loses arbitration, never prevents another queue from dispatching.
- R3: While pause is high, disp_valid stays low. Completion reports and suspensions still lower active_count.
- R4: Among candidates, the grid with the numerically largest priority (3 highest, 0 lowest) is dispatched first.
- R5: Among candidates of equal top priority, the winner is the first source found scanning upward from a rotating pointer, wrapping around. Sources 0..NQ-1 are the host queues and source NQ is the device side. After each dispatch the pointer moves to the winner plus one, and disp_src reports the winner.
- R6: A child launch accepted in cycle t (dev_suspend=0) is a dispatch candidate from cycle t+1. It is ranked by its own priority against all other pending work.
- R7: An accepted child launch increments the counter of dev_parent. A completion report for a grid that was launched as a child decrements its parent's counter once, and clears the record of that child.
- R8: An accepted suspension (dev_suspend=1) removes the grid from the active count in the same cycle and parks it in the device pool. It becomes a candidate in the cycle after its own child counter first reads zero.
- R9: A completion report frees its active slot in the cycle it is presented, so a dispatch may occur in that same cycle when the block was full.
- R10: sub_ready[q] is low exactly when queue q holds QDEPTH grids, and dev_ready is low exactly when all NDEV pool entries are occupied. Every grid offered while ready is high is eventually dispatched.
- R11: After reset no grid is pending or active: disp_valid is low, active_count is 0, and every ready output is high.
- R12: Within the device pool the candidate is the ready entry with the highest priority, with ties going to the lowest storage position. Entries are stored in the lowest free position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_valid | input | NQ | Per-queue submission valid |
| sub_ready | output | NQ | Per-queue submission ready |
| sub_id | input | NQ*IDW | Per-queue grid identifier, queue q in bits q*IDW upward |
| sub_prio | input | NQ*2 | Per-queue grid priority, queue q in bits 2q upward |
| dev_valid | input | 1 | Device-side request valid |
| dev_ready | output | 1 | Device-side request ready |
| dev_suspend | input | 1 | 1 = suspending parent, 0 = child launch |
| dev_id | input | IDW | Child or parent identifier |
| dev_prio | input | 2 | Priority of the request |
| dev_parent | input | IDW | Parent of a launched child |
| done_valid | input | 1 | Completion report strobe |
| done_id | input | IDW | Identifier of the completed grid |
| pause | input | 1 | Hold off new dispatch |
| disp_valid | output | 1 | Dispatch strobe |
| disp_id | output | IDW | Dispatched grid identifier |
| disp_prio | output | 2 | Dispatched grid priority |
| disp_src | output | $clog2(NQ+1) | Winning source index |
| active_count | output | $clog2(MAX_ACT+1) | Grids currently active |

## Verification
Grids are first staged with pause high across queues of equal priority and one of higher priority. On release, this separates strict priority from the rotation among sources. Filling the distributor and then sending a lone completion shows whether the freed slot is reused in the same cycle. Filling one queue and the device pool shows the ready outputs falling at the exact depth. A parent that suspends with two children outstanding must stay parked through the first completion and return only after the second. A long random mix of submissions, launches, suspensions, completions and pauses is compared against a behavioural model on every cycle, which catches ordering errors that the directed cases leave unvisited.

// File: rtl/gdm_pkg.sv
package gdm_pkg;
    localparam int PRIO_W = 2;
    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/gdm_hostq.sv
// One host submission queue: in-order storage, head is the only candidate.
// DEPTH must be a power of two, at least 2.
module gdm_hostq
    import gdm_pkg::*;
#(
    parameter int IDW   = 4,
    parameter int DEPTH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [IDW-1:0] push_id,
    input  prio_t          push_prio,
    input  logic           pop,
    output logic           full,
    output logic           nonempty,
    output logic [IDW-1:0] head_id,
    output prio_t          head_prio
);
    localparam int PW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][IDW-1:0]    ids;
        logic [DEPTH-1:0][PRIO_W-1:0] prs;
        logic [PW-1:0]                rd;
        logic [PW-1:0]                wr;
        logic [CNTW-1:0]              cnt;
    } hq_t;

    hq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.ids[s_q.wr] = push_id;
            s_d.prs[s_q.wr] = push_prio;
            s_d.wr          = s_q.wr + 1'b1;
        end
        if (pop) begin
            s_d.rd = s_q.rd + 1'b1;
        end
        s_d.cnt = s_q.cnt + CNTW'(push) - CNTW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign full      = (s_q.cnt == CNTW'(DEPTH));
    assign nonempty  = (s_q.cnt != '0);
    assign head_id   = s_q.ids[s_q.rd];
    assign head_prio = s_q.prs[s_q.rd];
endmodule

// File: rtl/gdm_deptrack.sv
// Outstanding-child counters per grid identifier, plus child-to-parent records.
module gdm_deptrack #(
    parameter int IDW = 4,
    parameter int CW  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [IDW-1:0]      launch_id,
    input  logic [IDW-1:0]      launch_par,
    input  logic                done,
    input  logic [IDW-1:0]      done_id,
    output logic [(1<<IDW)-1:0] idle
);
    localparam int NID = 1 << IDW;

    typedef struct packed {
        logic [NID-1:0][CW-1:0]  cnt;
        logic [NID-1:0]          is_child;
        logic [NID-1:0][IDW-1:0] par;
    } dt_t;

    dt_t  s_d, s_q;
    logic child_done;

    always_comb begin
        s_d        = s_q;
        child_done = done && s_q.is_child[done_id];
        if (child_done) begin
            s_d.is_child[done_id] = 1'b0;
        end
        if (launch) begin
            s_d.is_child[launch_id] = 1'b1;
            s_d.par[launch_id]      = launch_par;
        end
        for (int i = 0; i < NID; i++) begin
            s_d.cnt[i] = s_q.cnt[i]
                       + CW'(launch && (launch_par == IDW'(i)))
                       - CW'(child_done && (s_q.par[done_id] == IDW'(i)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        for (int i = 0; i < NID; i++) begin
            idle[i] = (s_q.cnt[i] == '0);
        end
    end
endmodule

// File: rtl/gdm_devpool.sv
// Device-side pool: launched children and suspended parents awaiting their children.
module gdm_devpool
    import gdm_pkg::*;
#(
    parameter int IDW = 4,
    parameter int N   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ins,
    input  logic                  ins_wait,
    input  logic [IDW-1:0]        ins_id,
    input  prio_t                 ins_prio,
    input  logic [(1<<IDW)-1:0]   idle,
    input  logic                  rm,
    input  logic [$clog2(N)-1:0]  rm_idx,
    output logic                  full,
    output logic                  cand_valid,
    output logic [$clog2(N)-1:0]  cand_idx,
    output logic [IDW-1:0]        cand_id,
    output prio_t                 cand_prio
);
    localparam int XW = $clog2(N);

    typedef struct packed {
        logic [N-1:0]             v;
        logic [N-1:0]             wt;
        logic [N-1:0][IDW-1:0]    ids;
        logic [N-1:0][PRIO_W-1:0] prs;
    } pool_t;

    pool_t         s_d, s_q;
    logic [XW-1:0] free_idx;
    logic          free_found;
    logic          rdy;

    always_comb begin
        free_idx   = '0;
        free_found = 1'b0;
        cand_valid = 1'b0;
        cand_idx   = '0;
        rdy        = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!s_q.v[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = XW'(i);
            end
            rdy = s_q.v[i] && (!s_q.wt[i] || idle[s_q.ids[i]]);
            if (rdy && (!cand_valid || (s_q.prs[i] > s_q.prs[cand_idx]))) begin
                cand_valid = 1'b1;
                cand_idx   = XW'(i);
            end
        end
    end

    assign full      = &s_q.v;
    assign cand_id   = s_q.ids[cand_idx];
    assign cand_prio = s_q.prs[cand_idx];

    always_comb begin
        s_d = s_q;
        if (rm) begin
            s_d.v[rm_idx] = 1'b0;
        end
        if (ins) begin
            s_d.v[free_idx]   = 1'b1;
            s_d.wt[free_idx]  = ins_wait;
            s_d.ids[free_idx] = ins_id;
            s_d.prs[free_idx] = ins_prio;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/gdm_arbiter.sv
// Strict priority across sources, rotating pointer among equal top priority.
module gdm_arbiter
    import gdm_pkg::*;
#(
    parameter int NSRC = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         req,
    input  prio_t [NSRC-1:0]        req_prio,
    input  logic                    go,
    output logic                    win_valid,
    output logic [$clog2(NSRC)-1:0] win_src
);
    localparam int SW = $clog2(NSRC);

    typedef struct packed {
        logic [SW-1:0] rr;
    } arb_t;

    arb_t  s_d, s_q;
    prio_t maxp;
    logic  found;
    int    idx;

    always_comb begin
        maxp = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (req[s] && (req_prio[s] > maxp)) maxp = req_prio[s];
        end
        found   = 1'b0;
        win_src = '0;
        idx     = 0;
        for (int k = 0; k < NSRC; k++) begin
            idx = int'(s_q.rr) + k;
            if (idx >= NSRC) idx = idx - NSRC;
            if (!found && req[idx] && (req_prio[idx] == maxp)) begin
                found   = 1'b1;
                win_src = SW'(idx);
            end
        end
        win_valid = |req;
        s_d       = s_q;
        if (go && win_valid) begin
            s_d.rr = (win_src == SW'(NSRC - 1)) ? '0 : win_src + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/grid_dispatch_mgr.sv
module grid_dispatch_mgr
    import gdm_pkg::*;
#(
    parameter int NQ      = 4,
    parameter int QDEPTH  = 4,
    parameter int NDEV    = 8,
    parameter int IDW     = 4,
    parameter int CW      = 4,
    parameter int MAX_ACT = 32,
    localparam int NSRC   = NQ + 1,
    localparam int SW     = $clog2(NSRC),
    localparam int AW     = $clog2(MAX_ACT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NQ-1:0]      sub_valid,
    output logic [NQ-1:0]      sub_ready,
    input  logic [NQ*IDW-1:0]  sub_id,
    input  logic [NQ*2-1:0]    sub_prio,
    input  logic               dev_valid,
    output logic               dev_ready,
    input  logic               dev_suspend,
    input  logic [IDW-1:0]     dev_id,
    input  logic [1:0]         dev_prio,
    input  logic [IDW-1:0]     dev_parent,
    input  logic               done_valid,
    input  logic [IDW-1:0]     done_id,
    input  logic               pause,
    output logic               disp_valid,
    output logic [IDW-1:0]     disp_id,
    output logic [1:0]         disp_prio,
    output logic [SW-1:0]      disp_src,
    output logic [AW-1:0]      active_count
);
    localparam int NID = 1 << IDW;
    localparam int XW  = $clog2(NDEV);

    typedef struct packed {
        logic [AW-1:0] act;
    } top_t;

    top_t                   s_d, s_q;
    logic [NSRC-1:0]        c_req;
    prio_t [NSRC-1:0]       c_pr;
    logic [NQ-1:0][IDW-1:0] h_id;
    logic [NQ-1:0]          h_full;
    logic                   pool_full;
    logic [XW-1:0]          pool_idx;
    logic [IDW-1:0]         pool_id;
    logic [NID-1:0]         idle;
    logic                   dev_acc;
    logic                   sus_acc;
    logic                   win_valid;
    logic [SW-1:0]          win_src;
    logic                   go;
    logic [AW-1:0]          eff;

    genvar q;
    generate
        for (q = 0; q < NQ; q++) begin : g_hq
            gdm_hostq #(.IDW(IDW), .DEPTH(QDEPTH)) u_q (
                .clk      (clk),
                .rst_n    (rst_n),
                .push     (sub_valid[q] && !h_full[q]),
                .push_id  (sub_id[q*IDW +: IDW]),
                .push_prio(sub_prio[q*2 +: 2]),
                .pop      (disp_valid && (win_src == SW'(q))),
                .full     (h_full[q]),
                .nonempty (c_req[q]),
                .head_id  (h_id[q]),
                .head_prio(c_pr[q])
            );
            assign sub_ready[q] = !h_full[q];
        end
    endgenerate

    assign dev_ready = !pool_full;
    assign dev_acc   = dev_valid && !pool_full;
    assign sus_acc   = dev_acc && dev_suspend;

    gdm_deptrack #(.IDW(IDW), .CW(CW)) u_dep (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (dev_acc && !dev_suspend),
        .launch_id (dev_id),
        .launch_par(dev_parent),
        .done      (done_valid),
        .done_id   (done_id),
        .idle      (idle)
    );

    gdm_devpool #(.IDW(IDW), .N(NDEV)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins       (dev_acc),
        .ins_wait  (dev_suspend),
        .ins_id    (dev_id),
        .ins_prio  (dev_prio),
        .idle      (idle),
        .rm        (disp_valid && (win_src == SW'(NQ))),
        .rm_idx    (pool_idx),
        .full      (pool_full),
        .cand_valid(c_req[NQ]),
        .cand_idx  (pool_idx),
        .cand_id   (pool_id),
        .cand_prio (c_pr[NQ])
    );

    gdm_arbiter #(.NSRC(NSRC)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (c_req),
        .req_prio (c_pr),
        .go       (go),
        .win_valid(win_valid),
        .win_src  (win_src)
    );

    // Slots released by completion or suspension are reusable in the same cycle.
    always_comb begin
        eff        = s_q.act - AW'(done_valid) - AW'(sus_acc);
        go         = !pause && (eff < AW'(MAX_ACT));
        disp_valid = win_valid && go;
        s_d.act    = eff + AW'(disp_valid);
        disp_id    = pool_id;
        for (int i = 0; i < NQ; i++) begin
            if (win_src == SW'(i)) disp_id = h_id[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign disp_prio    = c_pr[win_src];
    assign disp_src     = win_src;
    assign active_count = s_q.act;
endmodule

// File: rtl/gdm_checker.sv
module gdm_checker #(
    parameter int NQ      = 4,
    parameter int MAX_ACT = 32,
    parameter int SW      = 3,
    parameter int AW      = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pause,
    input logic          done_valid,
    input logic          dev_valid,
    input logic          dev_ready,
    input logic          dev_suspend,
    input logic          disp_valid,
    input logic [SW-1:0] disp_src,
    input logic [AW-1:0] active_count
);
    logic sus_acc;
    assign sus_acc = dev_valid && dev_ready && dev_suspend;

    AST_ACT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(active_count) <= MAX_ACT); // R1

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(active_count) == MAX_ACT && !done_valid && !sus_acc) |-> !disp_valid); // R1

    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pause |-> !disp_valid); // R3

    AST_SLOT_ACCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(active_count) == int'($past(active_count)) + int'($past(disp_valid))
                  - int'($past(done_valid)) - int'($past(sus_acc)))); // R9

    AST_SRC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (int'(disp_src) <= NQ)); // R5
endmodule

bind grid_dispatch_mgr gdm_checker #(
    .NQ(NQ), .MAX_ACT(MAX_ACT), .SW(SW), .AW(AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pause       (pause),
    .done_valid  (done_valid),
    .dev_valid   (dev_valid),
    .dev_ready   (dev_ready),
    .dev_suspend (dev_suspend),
    .disp_valid  (disp_valid),
    .disp_src    (disp_src),
    .active_count(active_count)
);

// File: tb/sim_grid_dispatch_mgr.sv
`timescale 1ns/1ps
module sim_grid_dispatch_mgr;
    localparam int NQ = 4, QD = 4, ND = 8, IDW = 4, CW = 4, MA = 6;
    localparam int NSRC = NQ + 1, SW = 3, AW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NQ-1:0] sub_valid = '0, sub_ready;
    logic [NQ*IDW-1:0] sub_id = '0;
    logic [NQ*2-1:0] sub_prio = '0;
    logic dev_valid = 1'b0, dev_ready, dev_suspend = 1'b0;
    logic [IDW-1:0] dev_id = '0, dev_parent = '0, done_id = '0, disp_id;
    logic [1:0] dev_prio = '0, disp_prio;
    logic done_valid = 1'b0, pause = 1'b0, disp_valid;
    logic [SW-1:0] disp_src;
    logic [AW-1:0] active_count;

    always #2 clk = ~clk;

    grid_dispatch_mgr #(.NQ(NQ), .QDEPTH(QD), .NDEV(ND), .IDW(IDW), .CW(CW), .MAX_ACT(MA)) u0 (
        .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_ready(sub_ready),
        .sub_id(sub_id), .sub_prio(sub_prio), .dev_valid(dev_valid), .dev_ready(dev_ready),
        .dev_suspend(dev_suspend), .dev_id(dev_id), .dev_prio(dev_prio), .dev_parent(dev_parent),
        .done_valid(done_valid), .done_id(done_id), .pause(pause), .disp_valid(disp_valid),
        .disp_id(disp_id), .disp_prio(disp_prio), .disp_src(disp_src), .active_count(active_count)
    );

    // Behavioural reference
    int hq [NQ][$];
    bit mv [ND]; bit mw [ND]; int mid [ND]; int mpr [ND];
    int cnt [16]; bit pv [16]; int pp [16];
    int act = 0, rr = 0;
    int running [$];
    bit e_disp, e_devrdy, e_sus;
    int e_id, e_prio, e_src, e_slot;
    bit [NQ-1:0] e_subrdy;

    int nchk = 0, nerr = 0;
    string cur_req = "R11";

    task automatic check(bit ok, string tag, string what, int a, int e);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, a, e, $time);
        end
    endtask

    function automatic void meval();
        int cp [NSRC]; bit cv [NSRC]; int maxp; int eff; int s;
        for (int q = 0; q < NQ; q++) begin
            cv[q] = hq[q].size() > 0;
            cp[q] = cv[q] ? hq[q][0] % 4 : 0;
            e_subrdy[q] = hq[q].size() < QD;
        end
        e_slot = -1;
        e_devrdy = 0;
        for (int i = 0; i < ND; i++) begin
            if (!mv[i]) e_devrdy = 1;
            if (mv[i] && (!mw[i] || cnt[mid[i]] == 0) && (e_slot < 0 || mpr[i] > mpr[e_slot])) e_slot = i;
        end
        cv[NQ] = e_slot >= 0;
        cp[NQ] = cv[NQ] ? mpr[e_slot] : 0;
        e_sus = dev_valid && e_devrdy && dev_suspend;
        eff = act - int'(done_valid) - int'(e_sus);
        maxp = -1;
        for (int k = 0; k < NSRC; k++) if (cv[k] && cp[k] > maxp) maxp = cp[k];
        e_disp = 0;
        if (!pause && eff < MA && maxp >= 0) begin
            for (int k = 0; k < NSRC; k++) begin
                s = (rr + k) % NSRC;
                if (!e_disp && cv[s] && cp[s] == maxp) begin e_disp = 1; e_src = s; end
            end
        end
        if (e_disp) begin
            e_prio = maxp;
            e_id = (e_src < NQ) ? hq[e_src][0] / 4 : mid[e_slot];
        end
    endfunction

    function automatic void mupdate();
        int fr = -1;
        for (int i = 0; i < ND; i++) if (!mv[i] && fr < 0) fr = i;
        if (e_disp) begin
            if (e_src < NQ) void'(hq[e_src].pop_front());
            else mv[e_slot] = 0;
            running.push_back(e_id);
            rr = (e_src + 1) % NSRC;
        end
        for (int q = 0; q < NQ; q++)
            if (sub_valid[q] && e_subrdy[q]) hq[q].push_back(int'(sub_id[q*IDW +: IDW]) * 4 + int'(sub_prio[q*2 +: 2]));
        if (done_valid && pv[done_id]) begin
            cnt[pp[done_id]] = (cnt[pp[done_id]] + 15) % 16;
            pv[done_id] = 0;
        end
        if (dev_valid && e_devrdy) begin
            mv[fr] = 1; mw[fr] = dev_suspend; mid[fr] = dev_id; mpr[fr] = dev_prio;
            if (!dev_suspend) begin
                cnt[dev_parent] = (cnt[dev_parent] + 1) % 16;
                pv[dev_id] = 1; pp[dev_id] = dev_parent;
            end
        end
        act = act - int'(done_valid) - int'(e_sus) + int'(e_disp);
    endfunction

    task automatic step();
        #1;
        meval();
        check(disp_valid == e_disp, cur_req, "disp_valid", disp_valid, e_disp);
        if (e_disp) begin
            check(disp_id == e_id, cur_req, "disp_id", disp_id, e_id);
            check(disp_prio == e_prio, "R4", "disp_prio", disp_prio, e_prio);
            check(disp_src == e_src, "R5", "disp_src", disp_src, e_src);
        end
        check(sub_ready == e_subrdy, "R10", "sub_ready", sub_ready, e_subrdy);
        check(dev_ready == e_devrdy, "R10", "dev_ready", dev_ready, e_devrdy);
        check(active_count == act, "R1", "active_count", active_count, act);
        @(posedge clk);
        mupdate();
        @(negedge clk);
        sub_valid = '0; dev_valid = 0; done_valid = 0;
    endtask

    task automatic sub(int q, int id, int pr);
        sub_valid[q] = 1'b1;
        sub_id[q*IDW +: IDW] = IDW'(id);
        sub_prio[q*2 +: 2] = 2'(pr);
    endtask

    task automatic dev(bit sus, int id, int pr, int par);
        dev_valid = 1'b1; dev_suspend = sus; dev_id = IDW'(id); dev_prio = 2'(pr); dev_parent = IDW'(par);
    endtask

    task automatic drop_running(int id);
        bit f = 0;
        for (int i = 0; i < running.size(); i++) begin
            if (!f && running[i] == id) begin running.delete(i); f = 1; end
        end
    endtask

    task automatic fin(int id);
        done_valid = 1'b1; done_id = IDW'(id);
        drop_running(id);
    endtask

    task automatic drain();
        bit busy;
        pause = 0;
        for (int n = 0; n < 400; n++) begin
            busy = running.size() > 0;
            for (int q = 0; q < NQ; q++) if (hq[q].size() > 0) busy = 1;
            for (int i = 0; i < ND; i++) if (mv[i]) busy = 1;
            if (!busy) break;
            if (running.size() > 0) fin(running[0]);
            step();
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R11";
        step(); step();

        // R2 R4 R5: staged with pause, then released
        cur_req = "R4";
        pause = 1;
        sub(0, 1, 1); sub(1, 3, 1); sub(2, 4, 3); step();
        sub(0, 2, 1); sub(3, 5, 1); step();
        pause = 0; cur_req = "R5";
        repeat (6) step();
        cur_req = "R2";
        check(running.size() == 5 && running[0] == 4, "R2", "first dispatched", running[0], 4);

        // R1 R9: fill to the limit, then a lone completion
        cur_req = "R1";
        pause = 1;
        sub(0, 6, 0); sub(1, 7, 0); sub(2, 8, 2); step();
        pause = 0;
        repeat (3) step();
        check(active_count == MA, "R1", "full count", active_count, MA);
        cur_req = "R9";
        fin(running[0]); step();
        step();

        // R3: pause with pending work, completions still count
        cur_req = "R3";
        pause = 1;
        sub(3, 9, 3); step();
        fin(running[0]); step();
        fin(running[0]); step();
        step();
        drain();

        // R10: queue depth and pool depth
        cur_req = "R10";
        pause = 1;
        for (int i = 0; i < 6; i++) begin sub(1, i, 1); step(); end
        for (int i = 0; i < 10; i++) begin dev(0, i, i % 4, 15); step(); end
        cur_req = "R12";
        drain();

        // R6 R7 R8: children, parent suspension and resumption
        cur_req = "R6";
        sub(0, 10, 0); step(); step();
        dev(0, 11, 2, 10); step();
        dev(0, 12, 1, 10); step();
        step();
        cur_req = "R8";
        dev(1, 10, 3, 0); drop_running(10); step();
        sub(2, 13, 0); step();
        step(); step();
        check(running.size() == 3 && running[2] == 13, "R8", "parent parked", running.size(), 3);
        cur_req = "R7";
        fin(11); step(); step();
        fin(12); step();
        step();
        check(running[running.size()-1] == 10, "R8", "parent resumed id", running[running.size()-1], 10);
        drain();

        // Random mix against the reference
        cur_req = "R12";
        for (int n = 0; n < 3000; n++) begin
            int dn = -1;
            pause = ($urandom % 10) == 0;
            for (int q = 0; q < NQ; q++) if ($urandom % 10 < 3) sub(q, $urandom % 16, $urandom % 4);
            if (running.size() > 0 && $urandom % 100 < 35) begin
                dn = running[$urandom % running.size()];
                fin(dn);
            end
            if (running.size() > 0 && $urandom % 100 < 12) begin
                int par = running[$urandom % running.size()];
                int cid = $urandom % 16;
                if (cid != dn) dev(0, cid, $urandom % 4, par);
            end else if (running.size() > 0 && $urandom % 100 < 6) begin
                int sid = running[$urandom % running.size()];
                dev(1, sid, $urandom % 4, 0);
                drop_running(sid);
            end
            step();
        end
        drain();
        report();
        $finish;
    end
endmodule